// File: doc/BRIEF.md
# Run-Length Bitstream Expander

This block turns a stream of compressed code bytes into a serial stream of single bits, ready to feed a serial configuration shifter. Each code byte describes a short run, and the block expands it into output bits. The code space has three run regions, and the split between them is set by the parameter `MAX_ONES`. Small codes give a run of ones that ends in a zero. The code just above `MAX_ONES` gives a bare run of ones with no end bit. Larger codes give a run of zeros that ends in a one. Codes 0 and 255 are no-ops and produce no bits.

Code bytes arrive on a ready/valid handshake, and bits leave on a single-bit ready/valid handshake. The block holds one code at a time. It takes the next code only after the downstream side has accepted the last bit of the current expansion, so bits always leave in the order the codes arrived. An `idle` output tells the surrounding logic that nothing is held and no bits remain to be sent.

Top module: `rle_bit_expander`

## Requirements
- R1: A code n with 1 <= n <= MAX_ONES produces n one-bits followed by one zero-bit.
- R2: The code MAX_ONES+1 produces exactly MAX_ONES one-bits and no trailing zero.
- R3: A code n with MAX_ONES+2 <= n <= 254 produces n-(MAX_ONES+2) zero-bits followed by one one-bit.
- R4: The code MAX_ONES+2 has a zero-length run. It produces a single one-bit, and that bit is valid in the cycle right after the code is accepted, with no stall cycle.
- R5: Codes 0 and 255 are accepted and produce no bits. After either code, `bit_valid` stays low and `idle` and `code_ready` stay high.
- R6: Bits leave strictly in the order in which their codes were accepted.
- R7: `code_ready` is low while any bit of the current expansion has not yet been accepted. It is high once none is outstanding.
- R8: While `bit_valid` is high and `bit_ready` is low, `bit_valid` stays high and `bit_data` holds its value.
- R9: In reset, and after reset, `idle` and `code_ready` are 1 and `bit_valid` is 0. A reset in the middle of an expansion drops the remaining bits.
- R10: The first bit of a non-empty expansion is valid in the cycle after its code is accepted. With `bit_ready` held high, each later bit follows one cycle after the one before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| code_valid | input | 1 | Code byte offered |
| code_ready | output | 1 | Block can take a code byte |
| code_byte | input | 8 | Compressed code byte |
| bit_valid | output | 1 | Output bit present |
| bit_ready | input | 1 | Downstream takes the bit |
| bit_data | output | 1 | Output bit value |
| idle | output | 1 | No code held and no bits remaining |

## Verification
The bench builds the block with `MAX_ONES` = 4. With that value all three regions are small enough to cover fully. It reaches both ends of the ones region (codes 1 and 4), the bare-ones code 5, and the zero-length code 6. It also reaches the longest zero run, 248 zeros from code 254. Some vectors stall `bit_ready` on a fixed pattern to check that bits hold under backpressure. An order-sensitive checksum over the whole stream checks that codes are not reordered.

// File: rtl/rle_exp_pkg.sv
package rle_exp_pkg;
  localparam int CODE_W = 8;
  typedef logic [CODE_W-1:0] code_t;

  typedef struct packed {
    code_t run_len;   // bits in the run body
    logic  run_bit;   // value of the run body bits
    logic  has_term;  // a closing bit follows the run
    logic  term_bit;  // value of the closing bit
  } plan_t;
endpackage

// File: rtl/rle_code_decoder.sv
module rle_code_decoder
  import rle_exp_pkg::*;
#(
  parameter int MAX_ONES = 8
) (
  input  code_t code,
  output plan_t plan
);
  localparam int ZERO_BASE = MAX_ONES + 2;
  localparam int CODE_MAX  = (1 << CODE_W) - 1;

  always_comb begin
    plan = '0;
    if (int'(code) >= 1 && int'(code) <= MAX_ONES) begin
      plan.run_len  = code;
      plan.run_bit  = 1'b1;
      plan.has_term = 1'b1;
      plan.term_bit = 1'b0;
    end else if (int'(code) == MAX_ONES + 1) begin
      plan.run_len  = CODE_W'(MAX_ONES);
      plan.run_bit  = 1'b1;
      plan.has_term = 1'b0;
    end else if (int'(code) >= ZERO_BASE && int'(code) < CODE_MAX) begin
      plan.run_len  = CODE_W'(int'(code) - ZERO_BASE);
      plan.run_bit  = 1'b0;
      plan.has_term = 1'b1;
      plan.term_bit = 1'b1;
    end
  end
endmodule

// File: rtl/rle_bit_engine.sv
module rle_bit_engine
  import rle_exp_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  load,
  input  plan_t plan_in,
  output logic  out_valid,
  output logic  out_data,
  input  logic  out_ready
);
  logic  valid_q, valid_d;
  logic  data_q, data_d;
  code_t left_q, left_d;
  logic  rbit_q, rbit_d;
  logic  term_q, term_d;
  logic  tbit_q, tbit_d;

  always_comb begin
    valid_d = valid_q;
    data_d  = data_q;
    left_d  = left_q;
    rbit_d  = rbit_q;
    term_d  = term_q;
    tbit_d  = tbit_q;
    if (load) begin
      rbit_d = plan_in.run_bit;
      tbit_d = plan_in.term_bit;
      if (plan_in.run_len != '0) begin
        valid_d = 1'b1;
        data_d  = plan_in.run_bit;
        left_d  = plan_in.run_len - 1'b1;
        term_d  = plan_in.has_term;
      end else if (plan_in.has_term) begin
        valid_d = 1'b1;
        data_d  = plan_in.term_bit;
        left_d  = '0;
        term_d  = 1'b0;
      end else begin
        valid_d = 1'b0;
      end
    end else if (valid_q && out_ready) begin
      if (left_q != '0) begin
        data_d = rbit_q;
        left_d = left_q - 1'b1;
      end else if (term_q) begin
        data_d = tbit_q;
        term_d = 1'b0;
      end else begin
        valid_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      data_q  <= 1'b0;
      left_q  <= '0;
      rbit_q  <= 1'b0;
      term_q  <= 1'b0;
      tbit_q  <= 1'b0;
    end else begin
      valid_q <= valid_d;
      data_q  <= data_d;
      left_q  <= left_d;
      rbit_q  <= rbit_d;
      term_q  <= term_d;
      tbit_q  <= tbit_d;
    end
  end

  assign out_valid = valid_q;
  assign out_data  = data_q;

  // R8
  hold_bit_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_data));
endmodule

// File: rtl/rle_bit_expander.sv
module rle_bit_expander
  import rle_exp_pkg::*;
#(
  parameter int MAX_ONES = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       code_valid,
  output logic       code_ready,
  input  logic [7:0] code_byte,
  output logic       bit_valid,
  input  logic       bit_ready,
  output logic       bit_data,
  output logic       idle
);
  plan_t plan;
  logic  load;

  assign load = code_valid && code_ready;

  rle_code_decoder #(.MAX_ONES(MAX_ONES)) u_dec (
    .code (code_byte),
    .plan (plan)
  );

  rle_bit_engine u_eng (
    .clk       (clk),
    .rst       (rst),
    .load      (load),
    .plan_in   (plan),
    .out_valid (bit_valid),
    .out_data  (bit_data),
    .out_ready (bit_ready)
  );

  assign code_ready = !bit_valid;
  assign idle       = !bit_valid;

  // R1
  ones_first_chk: assert property (@(posedge clk) disable iff (rst)
    load && int'(code_byte) >= 1 && int'(code_byte) <= MAX_ONES + 1
    |=> bit_valid && bit_data);
  // R3
  zeros_first_chk: assert property (@(posedge clk) disable iff (rst)
    load && int'(code_byte) >= MAX_ONES + 3 && int'(code_byte) <= 254
    |=> bit_valid && !bit_data);
  // R4
  zero_run_chk: assert property (@(posedge clk) disable iff (rst)
    load && int'(code_byte) == MAX_ONES + 2 |=> bit_valid && bit_data);
  // R5
  noop_code_chk: assert property (@(posedge clk) disable iff (rst)
    load && (code_byte == 8'd0 || code_byte == 8'd255)
    |=> idle && !bit_valid && code_ready);
  // R7
  busy_block_chk: assert property (@(posedge clk) disable iff (rst)
    bit_valid && !bit_ready |=> !code_ready);
endmodule

// File: tb/rle_bit_expander_test.sv
module rle_bit_expander_test;
  localparam int M = 4;
  localparam int NV = 14;
  localparam logic [7:0] CODES [NV] =
    '{8'd1, 8'd4, 8'd5, 8'd6, 8'd7, 8'd0, 8'd255, 8'd2,
      8'd3, 8'd10, 8'd254, 8'd100, 8'd6, 8'd5};
  localparam bit STALL [NV] =
    '{1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1,
      1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic code_valid = 1'b0;
  logic code_ready;
  logic [7:0] code_byte = 8'd0;
  logic bit_valid;
  logic bit_ready = 1'b0;
  logic bit_data;
  logic idle;

  int checks = 0;
  int fails  = 0;
  int exp_sum = 0;
  int act_sum = 0;
  int exp_tot = 0;
  int act_tot = 0;

  always #5 clk = ~clk;

  rle_bit_expander #(.MAX_ONES(M)) uut (
    .clk(clk), .rst(rst), .code_valid(code_valid), .code_ready(code_ready),
    .code_byte(code_byte), .bit_valid(bit_valid), .bit_ready(bit_ready),
    .bit_data(bit_data), .idle(idle)
  );

  function automatic int exp_len(int c);
    if (c >= 1 && c <= M) return c + 1;
    if (c == M + 1) return M;
    if (c >= M + 2 && c <= 254) return c - (M + 2) + 1;
    return 0;
  endfunction

  function automatic logic exp_bit(int c, int i);
    if (c >= 1 && c <= M) return (i < c);
    if (c == M + 1) return 1'b1;
    return (i >= c - (M + 2));
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic expand(int c, bit stall);
    int n = 0;
    int len = exp_len(c);
    int guard = 0;
    logic prev_stall = 1'b0;
    logic prev_data = 1'b0;
    @(negedge clk);
    code_valid = 1'b1;
    code_byte  = 8'(c);
    @(posedge clk);
    @(negedge clk);
    code_valid = 1'b0;
    // R10 / R5: first bit presence right after acceptance
    check(len > 0 ? "R10 first bit" : "R5 noop idle", int'(bit_valid), len > 0 ? 1 : 0);
    if (len == 0) check("R5 ready after noop", int'(code_ready && idle), 1);
    while (bit_valid && guard < 1000) begin
      guard++;
      // R7: no new code taken while bits remain
      if (code_ready) check("R7 ready while busy", 1, 0);
      if (prev_stall) check("R8 hold under stall", int'(bit_data), int'(prev_data));
      bit_ready = !(stall && (guard % 3 == 1));
      prev_stall = !bit_ready;
      prev_data  = bit_data;
      if (bit_ready) begin
        if (n < len)
          check(c <= M ? "R1 bit" : (c == M + 1 ? "R2 bit" : "R3 bit"),
                int'(bit_data), int'(exp_bit(c, n)));
        act_sum = act_sum * 3 + int'(bit_data) + 1;
        n++;
      end
      @(posedge clk);
      @(negedge clk);
    end
    bit_ready = 1'b0;
    check(c == M + 2 ? "R4 length" : "R1 R2 R3 length", n, len);
    for (int i = 0; i < len; i++) exp_sum = exp_sum * 3 + int'(exp_bit(c, i)) + 1;
    exp_tot += len;
    act_tot += n;
    check("R7 ready after last bit", int'(code_ready), 1);
  endtask

  initial begin
    #1500000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R9 state while reset is held
    check("R9 reset idle", int'(idle), 1);
    check("R9 reset valid", int'(bit_valid), 0);
    rst = 1'b0;
    @(negedge clk);
    check("R9 ready after reset", int'(code_ready), 1);

    for (int v = 0; v < NV; v++) expand(int'(CODES[v]), STALL[v]);

    // R6: order-sensitive checksum over whole stream
    check("R6 stream order", act_sum, exp_sum);
    check("R6 stream total", act_tot, exp_tot);

    // R10: back-to-back bits with ready high (code 3 -> 1110)
    @(negedge clk);
    code_valid = 1'b1; code_byte = 8'd3; bit_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    code_valid = 1'b0;
    for (int i = 0; i < 4; i++) begin
      check("R10 streaming", int'(bit_valid && (bit_data == (i < 3))), 1);
      @(negedge clk);
    end
    check("R10 done", int'(idle), 1);
    bit_ready = 1'b0;

    // R9: reset mid-expansion drops remaining bits
    @(negedge clk);
    code_valid = 1'b1; code_byte = 8'd200;
    @(negedge clk);
    code_valid = 1'b0;
    check("R9 busy before reset", int'(bit_valid), 1);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R9 dropped after reset", int'(idle && !bit_valid), 1);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule